// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a small processor core that finishes every instruction in one clock. It runs a nine-instruction integer subset: three-register arithmetic and logic (add, sub, and, or, set-less-than), add-immediate, word load, word store and branch-if-equal. The core holds the program counter, a 32 x 32-bit register file with two combinational read ports and one write port, a sign extender, one shared ALU with a zero flag, and a combinational decoder. The decoder emits one control word per instruction. That word picks the ALU's second operand, the ALU function, the write-back source, the destination register and the memory and register write enables.

The same ALU forms arithmetic results, load/store addresses and the branch comparison. Instruction and data storage are internal word arrays. The instruction array is filled through a load port while reset is held. The core reports each cycle's register write, memory write and current PC on its ports. Two peek ports expose any register and any data word so that a checker can compare architectural state.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register and data word becomes 0. After `rst` falls, the first instruction fetched is the word at instruction index 0.
- R2: When an instruction is not a taken branch, the PC at the next rising edge is PC+4. The fetch index is PC[IAW+1:2].
- R3: With opcode bits [31:26] = 0x00, the funct field [5:0] selects the operation: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A set-less-than. The operation is applied to registers rs [25:21] and rt [20:16], and the result is written to rd [15:11].
- R4: Set-less-than writes 1 when rs < rt as signed 32-bit values, and 0 otherwise.
- R5: Opcode 0x08 (addi) writes rs plus the sign-extended imm [15:0] into rt.
- R6: Opcode 0x23 (load) reads the data word at byte address rs + sext(imm) and writes it into rt. The word index is address[DAW+1:2].
- R7: Opcode 0x2B (store) writes rt to the data word at rs + sext(imm) and performs no register write.
- R8: Opcode 0x04 (beq) compares rs and rt. If they are equal, the next PC is PC+4+(sext(imm)<<2). Otherwise it is PC+4. No register or memory write occurs.
- R9: Register 0 always reads as 0. A write aimed at register 0 leaves it unchanged.
- R10: Any other opcode, and any other funct under opcode 0x00, performs no register write and no memory write. The PC still advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Instruction array write enable |
| ld_addr | input | IAW | Instruction word index to write |
| ld_word | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction fetched at pc_o |
| rf_we_o | output | 1 | Register write requested this cycle |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Value to be written back |
| dm_we_o | output | 1 | Data word write this cycle |
| dm_addr_o | output | 32 | Data byte address (ALU result) |
| dm_wdata_o | output | 32 | Data to be stored |
| peek_reg_sel | input | 5 | Register index to observe |
| peek_reg_val | output | 32 | Value of the observed register |
| peek_mem_sel | input | DAW | Data word index to observe |
| peek_mem_val | output | 32 | Value of the observed data word |

## Verification
The bench builds the core with IMEM_WORDS=64 and DMEM_WORDS=32. With 64 instruction words there is room for a straight-line program with forward branches that skip code, a branch that falls through, illegal words and a final backward loop. The 32-word data array lets a negative offset from a nonzero base hit low words. On every cycle a behavioural reference model predicts the PC and the register and memory writes. After the run, the model's registers and data words are compared through the peek ports.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN = 32;
    localparam int RAW  = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_ADDI  = 6'h08;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic [5:0]     op;
        logic [RAW-1:0] rs;
        logic [RAW-1:0] rt;
        logic [RAW-1:0] rd;
        logic [4:0]     shamt;
        logic [5:0]     funct;
    } rfmt_t;

    typedef struct packed {
        logic    reg_write;
        logic    alu_src;
        alu_op_e alu_op;
        logic    mem_read;
        logic    mem_write;
        logic    mem_to_reg;
        logic    branch;
        logic    dst_is_rd;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic is_legal(input logic [31:0] w);
        logic [5:0] op;
        logic [5:0] fn;
        op = w[31:26];
        fn = w[5:0];
        if (op == OP_RTYPE)
            return (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
                   (fn == FN_OR)  || (fn == FN_SLT);
        return (op == OP_LW) || (op == OP_SW) || (op == OP_BEQ) || (op == OP_ADDI);
    endfunction
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  rfmt_t ins,
    output ctrl_t ctl
);
    always_comb begin
        ctl = '0;
        ctl.alu_op = ALU_ADD;
        unique case (ins.op)
            OP_RTYPE: begin
                ctl.dst_is_rd = 1'b1;
                ctl.reg_write = 1'b1;
                unique case (ins.funct)
                    FN_ADD:  ctl.alu_op = ALU_ADD;
                    FN_SUB:  ctl.alu_op = ALU_SUB;
                    FN_AND:  ctl.alu_op = ALU_AND;
                    FN_OR:   ctl.alu_op = ALU_OR;
                    FN_SLT:  ctl.alu_op = ALU_SLT;
                    default: ctl.reg_write = 1'b0;
                endcase
            end
            OP_LW: begin
                ctl.reg_write  = 1'b1;
                ctl.alu_src    = 1'b1;
                ctl.mem_read   = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            OP_SW: begin
                ctl.alu_src   = 1'b1;
                ctl.mem_write = 1'b1;
            end
            OP_ADDI: begin
                ctl.reg_write = 1'b1;
                ctl.alu_src   = 1'b1;
            end
            OP_BEQ: begin
                ctl.alu_op = ALU_SUB;
                ctl.branch = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] res,
    output logic            zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: res = a + b;
            ALU_SUB: res = a - b;
            ALU_AND: res = a & b;
            ALU_OR:  res = a | b;
            ALU_SLT: res = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: res = '0;
        endcase
    end

    assign zero = (res == '0);

    // R4: a set-less-than result is a single bit
    always_comb begin
        if (op == ALU_SLT)
            a_r4_slt_bool: assert (res[XLEN-1:1] == '0);
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    ra_a,
    output logic [WIDTH-1:0] rd_a,
    input  logic [AW-1:0]    ra_b,
    output logic [WIDTH-1:0] rd_b,
    input  logic [AW-1:0]    ra_c,
    output logic [WIDTH-1:0] rd_c,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);
    logic [WIDTH-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_c = regs[ra_c];

    // R9: index 0 keeps reading zero after any writes
    a_r9_zero_reads: assert property (@(posedge clk) disable iff (rst)
        (ra_a == '0) |-> (rd_a == '0));
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic [IAW-1:0]  ld_addr,
    input  logic [31:0]     ld_word,
    output logic [31:0]     pc_o,
    output logic [31:0]     instr_o,
    output logic            rf_we_o,
    output logic [4:0]      rf_waddr_o,
    output logic [31:0]     rf_wdata_o,
    output logic            dm_we_o,
    output logic [31:0]     dm_addr_o,
    output logic [31:0]     dm_wdata_o,
    input  logic [4:0]      peek_reg_sel,
    output logic [31:0]     peek_reg_val,
    input  logic [DAW-1:0]  peek_mem_sel,
    output logic [31:0]     peek_mem_val
);
    logic [31:0]     imem [IMEM_WORDS];
    logic [31:0]     dmem [DMEM_WORDS];
    logic [31:0]     pc_q;
    logic [31:0]     instr;
    rfmt_t           ins;
    ctrl_t           ctl;
    logic [31:0]     imm_x;
    logic [31:0]     rs_val, rt_val;
    logic [31:0]     alu_b, alu_res;
    logic            alu_zero;
    logic [31:0]     rd_mem;
    logic [31:0]     wb_val;
    logic [RAW-1:0]  wb_idx;
    logic [31:0]     pc_plus4, br_tgt, pc_next;
    logic [DAW-1:0]  dm_idx;

    always_ff @(posedge clk) begin
        if (ld_en) imem[ld_addr] <= ld_word;
    end

    assign instr = imem[pc_q[IAW+1:2]];
    assign ins   = rfmt_t'(instr);
    assign imm_x = sext16(instr[15:0]);

    sc_ctrl u_ctrl (.ins(ins), .ctl(ctl));

    sc_regfile #(.NREG(32), .WIDTH(XLEN)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra_a(ins.rs),
        .rd_a(rs_val),
        .ra_b(ins.rt),
        .rd_b(rt_val),
        .ra_c(peek_reg_sel),
        .rd_c(peek_reg_val),
        .we  (ctl.reg_write),
        .wa  (wb_idx),
        .wd  (wb_val)
    );

    assign alu_b = ctl.alu_src ? imm_x : rt_val;

    sc_alu u_alu (
        .a   (rs_val),
        .b   (alu_b),
        .op  (ctl.alu_op),
        .res (alu_res),
        .zero(alu_zero)
    );

    assign dm_idx = alu_res[DAW+1:2];
    assign rd_mem = ctl.mem_read ? dmem[dm_idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
        end else if (ctl.mem_write) begin
            dmem[dm_idx] <= rt_val;
        end
    end

    assign wb_val = ctl.mem_to_reg ? rd_mem : alu_res;
    assign wb_idx = ctl.dst_is_rd ? ins.rd : ins.rt;

    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {imm_x[29:0], 2'b00};
    assign pc_next  = (ctl.branch && alu_zero) ? br_tgt : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o         = pc_q;
    assign instr_o      = instr;
    assign rf_we_o      = ctl.reg_write;
    assign rf_waddr_o   = wb_idx;
    assign rf_wdata_o   = wb_val;
    assign dm_we_o      = ctl.mem_write;
    assign dm_addr_o    = alu_res;
    assign dm_wdata_o   = rt_val;
    assign peek_mem_val = dmem[peek_mem_sel];

    // R2: without a taken branch the PC steps by one word
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        !(ctl.branch && (rs_val == rt_val)) |=> (pc_q == $past(pc_q) + 32'd4));

    // R8: equal operands on beq redirect to the offset target
    a_r8_branch_taken: assert property (@(posedge clk) disable iff (rst)
        (ins.op == OP_BEQ && rs_val == rt_val) |=>
        (pc_q == $past(pc_q) + 32'd4 + ($past(imm_x) << 2)));

    // R7: a store never writes back to a register
    a_r7_store_no_wb: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !rf_we_o);

    // R10: an unknown encoding makes no write of any kind
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        !is_legal(instr) |-> (!rf_we_o && !dm_we_o));
endmodule

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
    localparam int PERIOD = 10;
    localparam int IMW = 64;
    localparam int DMW = 32;
    localparam int IAW = $clog2(IMW);
    localparam int DAW = $clog2(DMW);
    localparam int RUN_CYCLES = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_en = 1'b0;
    logic [IAW-1:0] ld_addr = '0;
    logic [31:0] ld_word = '0;
    logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic rf_we_o, dm_we_o;
    logic [4:0] rf_waddr_o;
    logic [4:0] peek_reg_sel = '0;
    logic [31:0] peek_reg_val, peek_mem_val;
    logic [DAW-1:0] peek_mem_sel = '0;

    always #(PERIOD/2) clk = ~clk;

    sc_core #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) dut_i (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_word(ld_word),
        .pc_o(pc_o), .instr_o(instr_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
        .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o),
        .dm_wdata_o(dm_wdata_o), .peek_reg_sel(peek_reg_sel), .peek_reg_val(peek_reg_val),
        .peek_mem_sel(peek_mem_sel), .peek_mem_val(peek_mem_val)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] mimem [IMW];
    logic [31:0] mreg [32];
    logic [31:0] mmem [DMW];
    logic [31:0] mpc;

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic build_program();
        for (int i = 0; i < IMW; i++) mimem[i] = 32'h0;
        mimem[0]  = enc_i(6'h08, 0, 1, 5);
        mimem[1]  = enc_i(6'h08, 0, 2, -3);
        mimem[2]  = enc_r(1, 2, 3, 6'h20);
        mimem[3]  = enc_r(2, 1, 4, 6'h22);
        mimem[4]  = enc_r(1, 2, 5, 6'h24);
        mimem[5]  = enc_r(1, 2, 6, 6'h25);
        mimem[6]  = enc_r(2, 1, 7, 6'h2A);
        mimem[7]  = enc_r(1, 2, 8, 6'h2A);
        mimem[8]  = enc_i(6'h08, 1, 0, 7);
        mimem[9]  = enc_r(0, 1, 9, 6'h20);
        mimem[10] = enc_i(6'h08, 0, 10, 8);
        mimem[11] = enc_i(6'h2B, 10, 1, 4);
        mimem[12] = enc_i(6'h2B, 10, 2, -4);
        mimem[13] = enc_i(6'h23, 0, 11, 12);
        mimem[14] = enc_i(6'h23, 10, 12, -4);
        mimem[15] = enc_i(6'h04, 1, 9, 2);
        mimem[16] = enc_i(6'h08, 0, 13, 99);
        mimem[17] = enc_i(6'h08, 0, 13, 98);
        mimem[18] = enc_i(6'h04, 1, 2, 5);
        mimem[19] = enc_i(6'h3F, 1, 17, 1);
        mimem[20] = enc_r(1, 2, 18, 6'h21);
        mimem[21] = enc_i(6'h08, 0, 14, 32'h7FFF);
        mimem[22] = enc_i(6'h08, 0, 15, 32'h8000);
        mimem[23] = enc_r(15, 14, 16, 6'h2A);
        mimem[24] = enc_i(6'h04, 0, 0, -2);
    endtask

    task automatic step_model();
        logic [31:0] w, a, b, imm, res, ea;
        logic [5:0] op, fn;
        int rs, rt, rd;
        bit legal_r;
        string tag;
        w  = mimem[mpc[IAW+1:2]];
        op = w[31:26];
        fn = w[5:0];
        rs = int'(w[25:21]);
        rt = int'(w[20:16]);
        rd = int'(w[15:11]);
        imm = sx(w[15:0]);
        a = mreg[rs];
        b = mreg[rt];
        ea = a + imm;
        legal_r = (fn == 6'h20) || (fn == 6'h22) || (fn == 6'h24) ||
                  (fn == 6'h25) || (fn == 6'h2A);

        chk("R2", "pc", pc_o, mpc);

        if (op == 6'h00 && legal_r) begin
            tag = (fn == 6'h2A) ? "R4" : "R3";
            case (fn)
                6'h20: res = a + b;
                6'h22: res = a - b;
                6'h24: res = a & b;
                6'h25: res = a | b;
                default: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            endcase
            chk(tag, "rf_we", 32'(rf_we_o), 32'd1);
            chk(tag, "waddr", 32'(rf_waddr_o), 32'(rd));
            chk(tag, "wdata", rf_wdata_o, res);
            chk(tag, "dm_we", 32'(dm_we_o), 32'd0);
            if (rd != 0) mreg[rd] = res;
            mpc = mpc + 4;
        end else if (op == 6'h08) begin
            tag = (rt == 0) ? "R9" : "R5";
            chk(tag, "rf_we", 32'(rf_we_o), 32'd1);
            chk(tag, "waddr", 32'(rf_waddr_o), 32'(rt));
            chk(tag, "wdata", rf_wdata_o, ea);
            chk(tag, "dm_we", 32'(dm_we_o), 32'd0);
            if (rt != 0) mreg[rt] = ea;
            mpc = mpc + 4;
        end else if (op == 6'h23) begin
            res = mmem[ea[DAW+1:2]];
            chk("R6", "rf_we", 32'(rf_we_o), 32'd1);
            chk("R6", "waddr", 32'(rf_waddr_o), 32'(rt));
            chk("R6", "wdata", rf_wdata_o, res);
            chk("R6", "dm_we", 32'(dm_we_o), 32'd0);
            if (rt != 0) mreg[rt] = res;
            mpc = mpc + 4;
        end else if (op == 6'h2B) begin
            chk("R7", "rf_we", 32'(rf_we_o), 32'd0);
            chk("R7", "dm_we", 32'(dm_we_o), 32'd1);
            chk("R7", "daddr", dm_addr_o, ea);
            chk("R7", "ddata", dm_wdata_o, b);
            mmem[ea[DAW+1:2]] = b;
            mpc = mpc + 4;
        end else if (op == 6'h04) begin
            chk("R8", "rf_we", 32'(rf_we_o), 32'd0);
            chk("R8", "dm_we", 32'(dm_we_o), 32'd0);
            if (a == b) mpc = mpc + 4 + (imm << 2);
            else        mpc = mpc + 4;
        end else begin
            chk("R10", "rf_we", 32'(rf_we_o), 32'd0);
            chk("R10", "dm_we", 32'(dm_we_o), 32'd0);
            mpc = mpc + 4;
        end
    endtask

    initial begin
        build_program();
        for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
        for (int i = 0; i < DMW; i++) mmem[i] = 32'h0;
        mpc = 32'h0;

        rst = 1'b1;
        for (int i = 0; i < IMW; i++) begin
            @(negedge clk);
            ld_en = 1'b1;
            ld_addr = IAW'(i);
            ld_word = mimem[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        #1;
        // R1: reset state of PC, registers and data words
        chk("R1", "pc", pc_o, 32'h0);
        peek_reg_sel = 5'd3;
        peek_mem_sel = DAW'(3);
        #1;
        chk("R1", "reg3", peek_reg_val, 32'h0);
        chk("R1", "mem3", peek_mem_val, 32'h0);
        chk("R1", "first fetch", instr_o, mimem[0]);

        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < RUN_CYCLES; c++) begin
            #1;
            step_model();
            @(negedge clk);
        end

        // Loop at the end of the program no longer changes state
        for (int i = 0; i < 32; i++) begin
            peek_reg_sel = 5'(i);
            #1;
            chk((i == 0) ? "R9" : "R3", $sformatf("reg%0d", i), peek_reg_val, mreg[i]);
        end
        for (int i = 0; i < DMW; i++) begin
            peek_mem_sel = DAW'(i);
            #1;
            chk("R7", $sformatf("mem%0d", i), peek_mem_val, mmem[i]);
        end
        // Skipped code after the taken branch never wrote r13
        chk("R8", "r13 untouched", mreg[13], 32'h0);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule